// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one clause-22 management transaction at a time towards an Ethernet PHY. A host gives it a start pulse along with a read/write flag, a 5-bit register address and 16 bits of write data. The block then builds a 64-bit frame and sends it MSB first on the data output, while it generates the management clock (MDC) itself. The frame holds 32 preamble ones, the start pattern, an opcode, the PHY address, the register address, a turnaround field and the data field.

Every bit takes three timed phases: MDC low while the bit is set up, MDC high, then MDC low again. Each phase lasts `PHASE_WAIT` system clocks. On a read, the block releases the data line from a fixed bit position inside the turnaround. It samples the input pin during the high phase of each of the 16 data bits. A one-cycle done pulse ends every transaction. The PHY address is a parameter and defaults to zero.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy and done are low, MDC is low, the data output is 1, the output enable is 1 and the read result is zero.
- R2: Frame bits 63..0 are sent MSB first. Bits 63..32 are ones, bits 31..30 are 01, bits 27..23 are the PHY address parameter (default 0) and bits 22..18 are the register address.
- R3: Frame bits 29..28 hold the opcode. It is 01 for a write and 10 for a read.
- R4: On a write, bits 17..16 are 10 and bits 15..0 carry the write data. The output enable stays high for the whole frame.
- R5: On a read, the output enable falls when bit 18 ends. It stays low through bits 17..0 and returns high when the transaction ends.
- R6: On a read, the input pin is sampled in the last system cycle of the MDC-high phase of each of bits 15..0. Each sample is stored at the same bit position of the read result.
- R7: Each bit lasts 3*PHASE_WAIT cycles. MDC is low for the first PHASE_WAIT cycles, high for the next PHASE_WAIT and low for the last PHASE_WAIT. A frame therefore lasts 192*PHASE_WAIT cycles.
- R8: A start accepted while idle makes busy high from the next cycle. Busy stays high for 192*PHASE_WAIT cycles. In the cycle where busy falls, done is high for exactly one cycle.
- R9: A start pulse while busy is ignored: the frame contents and the timing are unchanged.
- R10: While idle, MDC is low, the data output is 1 and the output enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled while idle |
| rdNotWr | input | 1 | 1 = read, 0 = write |
| regAddr | input | 5 | PHY register address |
| wrData | input | 16 | Data for write transactions |
| rdData | output | 16 | Result of the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data output |
| mdoEn | output | 1 | Data output driver enable |
| mdi | input | 1 | Management data input |

## Verification
The assertions check on every cycle the relations among busy, done and start. They also check the idle levels of the three line outputs, and that the driver stays enabled throughout a write. Three things need the bench's scenarios: the frame contents as a PHY model sees them at MDC rising edges, the exact phase timing, and the position at which the line is released on reads. The bench also shows that read data lands at the correct bit positions and that a start raised mid-frame leaves the transfer untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic load;     // build a new frame from the host inputs
    logic shift;    // move to the next frame bit
    logic capture;  // sample the input pin into the read result
    logic active;   // a frame is being sent
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PHASE_WAIT = 25
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         rdNotWr,
  output mdioStrobes_t strobes,
  output logic         busy,
  output logic         done,
  output logic         mdc,
  output logic         mdoEn
);
  localparam int CNT_W        = $clog2(PHASE_WAIT + 1);
  localparam int RELEASE_IDX  = 18;
  localparam int CAPTURE_TOP  = DATA_BITS;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t     state;
  logic [CNT_W-1:0] phaseCnt;
  logic [1:0]     phase;
  logic [IDX_W-1:0] bitIdx;
  logic           isRead;
  logic           enR;
  logic           doneR;

  logic accept, running, phaseEnd, bitEnd;

  assign running  = (state == ST_RUN);
  assign accept   = (state == ST_IDLE) && start;
  assign phaseEnd = (phaseCnt == CNT_W'(PHASE_WAIT - 1));
  assign bitEnd   = running && phaseEnd && (phase == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      phase    <= '0;
      bitIdx   <= '0;
      isRead   <= 1'b0;
      enR      <= 1'b1;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (accept) begin
        state    <= ST_RUN;
        phaseCnt <= '0;
        phase    <= '0;
        bitIdx   <= IDX_W'(FRAME_BITS - 1);
        isRead   <= rdNotWr;
        enR      <= 1'b1;
      end else if (running) begin
        if (!phaseEnd) begin
          phaseCnt <= phaseCnt + 1'b1;
        end else begin
          phaseCnt <= '0;
          if (phase == 2'd2) begin
            phase <= '0;
            if (bitIdx == '0) begin
              state <= ST_IDLE;
              doneR <= 1'b1;
              enR   <= 1'b1;
            end else begin
              bitIdx <= bitIdx - 1'b1;
              if (isRead && bitIdx == IDX_W'(RELEASE_IDX)) enR <= 1'b0;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strobes.load    = accept;
    strobes.shift   = bitEnd && (bitIdx != '0);
    strobes.capture = running && (phase == 2'd1) && phaseEnd && isRead &&
                      (bitIdx < IDX_W'(CAPTURE_TOP));
    strobes.active  = running;
  end

  assign busy  = running;
  assign done  = doneR;
  assign mdc   = running && (phase == 2'd1);
  assign mdoEn = enR;
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrobes_t         strobes,
  input  logic                 rdNotWr,
  input  logic [4:0]           regAddr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 mdi,
  output logic                 mdo,
  output logic [DATA_BITS-1:0] rdData
);
  localparam int PRE_BITS = 32;

  logic [FRAME_BITS-1:0] frameSr;
  logic [DATA_BITS-1:0]  rdSr;
  logic [1:0]            opCode;
  logic [DATA_BITS-1:0]  dataField;

  assign opCode    = rdNotWr ? 2'b10 : 2'b01;
  assign dataField = rdNotWr ? '0 : wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '1;
      rdSr    <= '0;
    end else begin
      if (strobes.load) begin
        frameSr <= {{PRE_BITS{1'b1}}, 2'b01, opCode, PHY_ADDR, regAddr,
                    2'b10, dataField};
        if (rdNotWr) rdSr <= '0;
      end else if (strobes.shift) begin
        frameSr <= {frameSr[FRAME_BITS-2:0], 1'b1};
      end
      if (strobes.capture) rdSr <= {rdSr[DATA_BITS-2:0], mdi};
    end
  end

  assign mdo    = strobes.active ? frameSr[FRAME_BITS-1] : 1'b1;
  assign rdData = rdSr;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         PHASE_WAIT = 25,
  parameter logic [4:0] PHY_ADDR   = 5'd0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdNotWr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdo,
  output logic        mdoEn,
  input  logic        mdi
);
  mdioStrobes_t strobes;

  mdio_ctrl #(.PHASE_WAIT(PHASE_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdNotWr(rdNotWr),
    .strobes(strobes), .busy(busy), .done(done), .mdc(mdc), .mdoEn(mdoEn)
  );

  mdio_datapath #(.PHY_ADDR(PHY_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdNotWr(rdNotWr),
    .regAddr(regAddr), .wrData(wrData), .mdi(mdi), .mdo(mdo),
    .rdData(rdData)
  );
endmodule

module mdio_master_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic rdNotWr,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdo,
  input logic mdoEn
);
  logic wasWrite;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasWrite <= 1'b0;
    else if (!busy && start) wasWrite <= !rdNotWr;
  end

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && mdo && mdoEn));
  // R4
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wasWrite) |-> mdoEn);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .rdNotWr(rdNotWr), .busy(busy),
  .done(done), .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2;
  localparam int FRAME_CYC = 192 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rdNotWr = 1'b0;
  logic [4:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic busy, done, mdc, mdo, mdoEn;
  logic mdi = 1'b1;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // PHY model state
  int nRise = 0;
  logic [63:0] seen = '0;
  logic [15:0] phyVal = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.PHASE_WAIT(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rdNotWr(rdNotWr),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .busy(busy),
    .done(done), .mdc(mdc), .mdo(mdo), .mdoEn(mdoEn), .mdi(mdi)
  );

  always @(posedge mdc) begin
    seen = {seen[62:0], mdo};
    nRise = nRise + 1;
  end

  always @(negedge mdc) begin
    if (nRise >= 48 && nRise < 64) mdi = phyVal[63 - nRise];
    else mdi = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", 64'(cycles), 64'd100000);
      summary();
    end
  end

  task automatic runTxn(input bit rd, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] pv,
                        input bit poke);
    logic [63:0] expFrame;
    expFrame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 5'd0, ra, 2'b10,
                (rd ? 16'h0 : wd)};
    nRise = 0;
    phyVal = pv;
    @(negedge clk);
    rdNotWr = rd; regAddr = ra; wrData = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= FRAME_CYC; t++) begin
      int bitNo, ph;
      bit expMdc, expEn, expBusy, expDone;
      bitNo = 63 - t / (3 * W);
      ph = (t / W) % 3;
      expBusy = (t < FRAME_CYC);
      expDone = (t == FRAME_CYC);
      expMdc  = expBusy && (ph == 1);
      expEn   = expBusy ? !(rd && bitNo <= 17) : 1'b1;
      // R7 phase timing, R8 busy/done, R5 release position
      chk(busy == expBusy, "R8 busy", 64'(busy), 64'(expBusy));
      chk(done == expDone, "R8 done", 64'(done), 64'(expDone));
      chk(mdc == expMdc, "R7 mdc phase", 64'(mdc), 64'(expMdc));
      chk(mdoEn == expEn, rd ? "R5 mdoEn" : "R4 mdoEn", 64'(mdoEn), 64'(expEn));
      if (expBusy && expEn)
        chk(mdo == expFrame[bitNo], "R2 mdo bit", 64'(mdo), 64'(expFrame[bitNo]));
      if (!expBusy)
        chk(mdo == 1'b1, "R10 idle mdo", 64'(mdo), 64'd1);
      if (poke && t == 50) begin
        start = 1'b1; rdNotWr = !rd; regAddr = ~ra; wrData = ~wd;
      end else begin
        start = 1'b0; rdNotWr = rd; regAddr = ra; wrData = wd;
      end
      if (t < FRAME_CYC) @(negedge clk);
    end
    chk(nRise == 64, "R7 edge count", 64'(nRise), 64'd64);
    chk(seen[63:30] == {32'hFFFF_FFFF, 2'b01}, "R2 preamble/start",
        64'(seen[63:30]), 64'({32'hFFFF_FFFF, 2'b01}));
    chk(seen[29:28] == (rd ? 2'b10 : 2'b01), "R3 opcode",
        64'(seen[29:28]), 64'(rd ? 2'b10 : 2'b01));
    chk(seen[27:18] == {5'd0, ra}, poke ? "R9 addr unchanged" : "R2 addresses",
        64'(seen[27:18]), 64'({5'd0, ra}));
    if (!rd) begin
      chk(seen[17:0] == {2'b10, wd}, poke ? "R9 data unchanged" : "R4 ta/data",
          64'(seen[17:0]), 64'({2'b10, wd}));
    end else begin
      chk(rdData == pv, "R6 read result", 64'(rdData), 64'(pv));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", 64'({busy, done}), 64'd0);
    chk(mdc == 1'b0 && mdo == 1'b1 && mdoEn == 1'b1, "R1 lines",
        64'({mdc, mdo, mdoEn}), 64'b011);
    chk(rdData == 16'h0, "R1 rdData", 64'(rdData), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R10 idle after reset release
    chk(mdc == 1'b0 && mdo == 1'b1 && mdoEn == 1'b1, "R10 idle",
        64'({mdc, mdo, mdoEn}), 64'b011);

    runTxn(1'b0, 5'h1B, 16'hA5C3, 16'h0, 1'b0);
    runTxn(1'b1, 5'h04, 16'h0, 16'h8E71, 1'b0);
    runTxn(1'b0, 5'h11, 16'h0F01, 16'h0, 1'b1);
    runTxn(1'b1, 5'h1F, 16'hFFFF, 16'h4C3A, 1'b1);
    runTxn(1'b1, 5'h00, 16'h0, 16'h8001, 1'b0);

    repeat (5) @(negedge clk);
    chk(mdc == 1'b0 && mdo == 1'b1 && mdoEn == 1'b1 && !busy, "R10 final idle",
        64'({busy, mdc, mdo, mdoEn}), 64'b0011);
    summary();
  end
endmodule